// File: doc/BRIEF.md
# Coprocessor Port Interface (slave side)

This block sits inside an attached numeric coprocessor. It answers the host processor's I/O cycles at three fixed port addresses. The host first reads the status port to see whether the coprocessor is busy. It then writes an opcode to the status port and writes two 16-bit values to the fault port: the instruction pointer and the effective address, which are held for fault reporting. If the opcode needs an operand, the block raises an operand request. The host then writes operand bytes to the operand port, each while it holds the acknowledge line.

The expected operand length depends on the opcode class. Once the last byte has arrived, the request drops and the opcode and the assembled operand are presented to the execution core. They stay presented until the core signals done, and that also clears the busy bit. Writes to the operand port that break the protocol are discarded and set a sticky error flag.

Top module: `cpx_port_if`

## Requirements
- R1: The block responds only when `io_sel` is high and `io_addr` is 0xF8 (status/opcode), 0xFA (operand) or 0xFC (fault addresses). Any other access changes no state.
- R2: A read of 0xF8 puts the status word on `io_rdata` one cycle after the read strobe. In the status word, bit 0 is busy, bit 1 is operand request and bit 2 is protocol error, and the upper bits are zero. A read of any other address returns zero.
- R3: An opcode write to 0xF8 while the block is idle loads `io_wdata[7:0]` into `exec_opcode` and sets busy.
- R4: The operand length comes from opcode bits [7:6]. Class 0 takes 0 bytes, class 1 takes 2, class 2 takes 4 and class 3 takes 8.
- R5: After an opcode is accepted, the first write to 0xFC loads `flt_ip` and the second loads `flt_ea`. Further writes alternate between the two.
- R6: For a nonzero length, `opnd_req` rises in the cycle after the opcode is accepted. It stays high until the last byte has been accepted and drops in the following cycle.
- R7: An accepted operand byte comes from `io_wdata[7:0]`. Byte k of the operation lands in `exec_operand[8k+7:8k]`, and unused bytes read zero.
- R8: `exec_valid` rises when the operand is complete, or in the cycle right after the opcode is accepted if the length is 0. It holds until `exec_done`, which clears both `exec_valid` and busy.
- R9: A write to 0xFA is ignored if `opnd_ack` is low or no request is pending. Such a write sets the protocol-error bit, which only reset clears.
- R10: An opcode write while busy is dropped, and the current operation continues unchanged.
- R11: After reset, busy, request, error, `exec_valid`, the fault registers and `io_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Chip select for the I/O cycle |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| opnd_ack | input | 1 | Host acknowledge qualifying operand writes |
| opnd_req | output | 1 | Operand request |
| flt_ip | output | 16 | Captured instruction pointer |
| flt_ea | output | 16 | Captured effective address |
| exec_valid | output | 1 | Opcode and operand ready for the core |
| exec_opcode | output | 8 | Latched opcode |
| exec_operand | output | 64 | Assembled operand bytes |
| exec_done | input | 1 | Core finished the operation |

## Verification
The hardest case to reach from the ports is a stray operand write that arrives in the middle of a collection, with no acknowledge, while the request is still high. A correct design must neither store that byte nor advance its byte count. The stimulus opens a four-byte operation and injects an unacknowledged 0xEE write before the real bytes. It then checks that the assembled operand contains only the acknowledged bytes, and that the status word shows busy and error with the request cleared. Opcode writes during collection and during the execute wait show that a busy block drops them.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EXEC    = 2'd2
  } cpx_state_e;

  // Operand length per opcode class: 0 -> none, otherwise 2^class bytes.
  function automatic int unsigned class_bytes(input logic [1:0] cls);
    return (cls == 2'd0) ? 0 : (1 << cls);
  endfunction
endpackage

// File: rtl/cpx_addr_dec.sv
module cpx_addr_dec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF8,
  parameter logic [ADDR_W-1:0] OPND_ADDR = 8'hFA,
  parameter logic [ADDR_W-1:0] FLT_ADDR  = 8'hFC
) (
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic              opnd_wr,
  output logic              flt_wr
);
  logic hit_stat, hit_opnd, hit_flt;

  always_comb begin
    hit_stat = io_sel && (io_addr == STAT_ADDR);
    hit_opnd = io_sel && (io_addr == OPND_ADDR);
    hit_flt  = io_sel && (io_addr == FLT_ADDR);
    stat_wr  = hit_stat && io_wr;
    stat_rd  = hit_stat && io_rd;
    opnd_wr  = hit_opnd && io_wr;
    flt_wr   = hit_flt && io_wr;
  end
endmodule

// File: rtl/cpx_opnd_buf.sv
module cpx_opnd_buf #(
  parameter int MAX_BYTES = 8,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             din,
  output logic [MAX_BYTES*8-1:0] dout
);
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        byte_q <= '0;
      else if (we && idx == IDX_W'(g))
        byte_q <= din;
    end
    assign dout[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_wr,
  input  logic             opnd_wr,
  input  logic             opnd_ack,
  input  logic             exec_done,
  input  logic [OPC_W-1:0] opc_in,
  output logic [OPC_W-1:0] opcode,
  output logic [CNT_W-1:0] nbytes,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             opnd_req,
  output logic             exec_valid,
  output logic             proto_err,
  output logic             op_accept,
  output logic             byte_take
);
  cpx_state_e state;
  logic [CNT_W-1:0] nb_d;
  logic bad_byte;

  always_comb begin
    nb_d      = CNT_W'(class_bytes(opc_in[OPC_W-1 -: 2]));
    op_accept = stat_wr && (state == ST_IDLE);
    byte_take = opnd_wr && opnd_ack && (state == ST_COLLECT);
    bad_byte  = opnd_wr && !(opnd_ack && (state == ST_COLLECT));
    busy       = (state != ST_IDLE);
    opnd_req   = (state == ST_COLLECT);
    exec_valid = (state == ST_EXEC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      opcode    <= '0;
      nbytes    <= '0;
      cnt       <= '0;
      proto_err <= 1'b0;
    end else begin
      if (bad_byte) proto_err <= 1'b1;
      unique case (state)
        ST_IDLE: if (stat_wr) begin
          opcode <= opc_in;
          nbytes <= nb_d;
          cnt    <= '0;
          state  <= (nb_d == '0) ? ST_EXEC : ST_COLLECT;
        end
        ST_COLLECT: if (byte_take) begin
          cnt <= cnt + 1'b1;
          if (cnt == nbytes - 1'b1) state <= ST_EXEC;
        end
        ST_EXEC: if (exec_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpx_port_if.sv
module cpx_port_if
  import cpx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int OPC_W     = 8,
  parameter int MAX_BYTES = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hF8,
  parameter logic [ADDR_W-1:0] OPND_ADDR = 8'hFA,
  parameter logic [ADDR_W-1:0] FLT_ADDR  = 8'hFC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   io_sel,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [DATA_W-1:0]      io_wdata,
  output logic [DATA_W-1:0]      io_rdata,
  input  logic                   opnd_ack,
  output logic                   opnd_req,
  output logic [DATA_W-1:0]      flt_ip,
  output logic [DATA_W-1:0]      flt_ea,
  output logic                   exec_valid,
  output logic [OPC_W-1:0]       exec_opcode,
  output logic [MAX_BYTES*8-1:0] exec_operand,
  input  logic                   exec_done
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic stat_wr, stat_rd, opnd_wr, flt_wr;
  logic busy, proto_err, op_accept, byte_take;
  logic [CNT_W-1:0] nbytes, cnt;
  logic flt_ptr;
  logic [DATA_W-1:0] status_w;

  cpx_addr_dec #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .OPND_ADDR(OPND_ADDR), .FLT_ADDR(FLT_ADDR)
  ) u_dec (
    .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .stat_wr(stat_wr), .stat_rd(stat_rd), .opnd_wr(opnd_wr), .flt_wr(flt_wr)
  );

  cpx_ctrl #(.OPC_W(OPC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .opnd_wr(opnd_wr),
    .opnd_ack(opnd_ack), .exec_done(exec_done), .opc_in(io_wdata[OPC_W-1:0]),
    .opcode(exec_opcode), .nbytes(nbytes), .cnt(cnt), .busy(busy),
    .opnd_req(opnd_req), .exec_valid(exec_valid), .proto_err(proto_err),
    .op_accept(op_accept), .byte_take(byte_take)
  );

  cpx_opnd_buf #(.MAX_BYTES(MAX_BYTES), .IDX_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .clr(op_accept), .we(byte_take), .idx(cnt),
    .din(io_wdata[7:0]), .dout(exec_operand)
  );

  // Fault address capture: alternating IP / EA, pointer rewinds per opcode.
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_ptr <= 1'b0;
      flt_ip  <= '0;
      flt_ea  <= '0;
    end else if (op_accept) begin
      flt_ptr <= 1'b0;
    end else if (flt_wr) begin
      if (!flt_ptr) flt_ip <= io_wdata;
      else          flt_ea <= io_wdata;
      flt_ptr <= ~flt_ptr;
    end
  end

  assign status_w = {{(DATA_W-3){1'b0}}, proto_err, opnd_req, busy};

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= stat_rd ? status_w : '0;
  end
endmodule

// File: rtl/cpx_port_if_chk.sv
module cpx_port_if_chk #(
  parameter int OPC_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             opnd_req,
  input logic             exec_valid,
  input logic             exec_done,
  input logic             proto_err,
  input logic [OPC_W-1:0] exec_opcode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] nbytes
);
  assert_valid_hold_R8: assert property (@(posedge clk) disable iff (rst)
    exec_valid && !exec_done |=> exec_valid);
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
    exec_valid && exec_done |=> !busy);
  assert_opcode_kept_R10: assert property (@(posedge clk) disable iff (rst)
    busy && !exec_done |=> $stable(exec_opcode));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  assert_req_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(opnd_req && exec_valid));
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= nbytes);
endmodule

bind cpx_port_if cpx_port_if_chk #(.OPC_W(OPC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .opnd_req(opnd_req),
  .exec_valid(exec_valid), .exec_done(exec_done), .proto_err(proto_err),
  .exec_opcode(exec_opcode), .cnt(cnt), .nbytes(nbytes)
);

// File: tb/tb_cpx_port_if.sv
module tb_cpx_port_if;
  logic clk = 1'b0, rst = 1'b1;
  logic io_sel = 0, io_wr = 0, io_rd = 0, opnd_ack = 0, exec_done = 0;
  logic [7:0] io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata, flt_ip, flt_ea;
  logic opnd_req, exec_valid;
  logic [7:0] exec_opcode;
  logic [63:0] exec_operand;
  int n_chk = 0, n_fail = 0;
  logic [15:0] rd;

  always #4 clk = ~clk;

  cpx_port_if dut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .opnd_ack(opnd_ack), .opnd_req(opnd_req), .flt_ip(flt_ip), .flt_ea(flt_ea),
    .exec_valid(exec_valid), .exec_opcode(exec_opcode),
    .exec_operand(exec_operand), .exec_done(exec_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] a, input logic [15:0] d, input logic ack);
    @(negedge clk);
    io_sel = sel; io_wr = 1; io_addr = a; io_wdata = d; opnd_ack = ack;
    @(negedge clk);
    io_sel = 0; io_wr = 0; opnd_ack = 0;
  endtask

  task automatic rdp(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    io_sel = 1; io_rd = 1; io_addr = a;
    @(negedge clk);
    io_sel = 0; io_rd = 0;
    d = io_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); exec_done = 1;
    @(negedge clk); exec_done = 0;
  endtask

  task automatic t_reset();
    chk("R11 req", opnd_req, 0);
    chk("R11 valid", exec_valid, 0);
    chk("R11 flt_ip", flt_ip, 0);
    chk("R11 rdata", io_rdata, 0);
    rdp(8'hF8, rd); chk("R11 status", rd, 0);
  endtask

  task automatic t_decode();
    wr(1, 8'hF9, 16'h0005, 0);
    wr(0, 8'hF8, 16'h0005, 0);
    wr(1, 8'hFD, 16'h1111, 0);
    rdp(8'hF8, rd); chk("R1 no busy after stray writes", rd, 0);
    chk("R1 flt_ip untouched", flt_ip, 0);
    rdp(8'hF9, rd); chk("R2 other address reads zero", rd, 0);
  endtask

  task automatic t_zero_byte();
    wr(1, 8'hF8, 16'h0005, 0);
    chk("R3 opcode latched", exec_opcode, 8'h05);
    chk("R8 zero-length valid", exec_valid, 1);
    chk("R4 class0 no req", opnd_req, 0);
    wr(1, 8'hFC, 16'h1234, 0);
    wr(1, 8'hFC, 16'hABCD, 0);
    chk("R5 ip", flt_ip, 16'h1234);
    chk("R5 ea", flt_ea, 16'hABCD);
    rdp(8'hF8, rd); chk("R2 status busy", rd, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R8 valid held", exec_valid, 1);
    done_pulse();
    chk("R8 done clears valid", exec_valid, 0);
    rdp(8'hF8, rd); chk("R8 done clears busy", rd, 0);
  endtask

  task automatic t_two_byte();
    wr(1, 8'hF8, 16'h004A, 0);
    chk("R6 req raised", opnd_req, 1);
    chk("R8 not yet valid", exec_valid, 0);
    wr(1, 8'hFC, 16'h5555, 0);
    chk("R5 pointer rewound", flt_ip, 16'h5555);
    wr(1, 8'hF8, 16'h003C, 0);
    chk("R10 opcode kept in collect", exec_opcode, 8'h4A);
    wr(1, 8'hFA, 16'h0011, 1);
    chk("R6 req held mid", opnd_req, 1);
    wr(1, 8'hFA, 16'h0022, 1);
    chk("R6 req dropped", opnd_req, 0);
    chk("R8 valid after last", exec_valid, 1);
    chk("R7 two-byte operand", exec_operand, 64'h2211);
    wr(1, 8'hF8, 16'h00C3, 0);
    chk("R10 opcode kept in exec", exec_opcode, 8'h4A);
    chk("R10 no req restart", opnd_req, 0);
    done_pulse();
  endtask

  task automatic t_eight_byte();
    wr(1, 8'hF8, 16'h00C1, 0);
    for (int i = 0; i < 7; i++) wr(1, 8'hFA, 16'h0010 + 16'(i), 1);
    chk("R4 class3 req after 7", opnd_req, 1);
    wr(1, 8'hFA, 16'h0017, 1);
    chk("R4 class3 done at 8", opnd_req, 0);
    chk("R7 eight-byte operand", exec_operand, 64'h1716151413121110);
    done_pulse();
  endtask

  task automatic t_proto_err();
    rdp(8'hF8, rd); chk("R9 err clear before", rd, 0);
    wr(1, 8'hF8, 16'h0081, 0);
    wr(1, 8'hFA, 16'h00EE, 0);
    chk("R9 req kept", opnd_req, 1);
    for (int i = 0; i < 3; i++) wr(1, 8'hFA, 16'h00A0 + 16'(i), 1);
    chk("R4 class2 req after 3", opnd_req, 1);
    wr(1, 8'hFA, 16'h00A3, 1);
    chk("R9 stray byte not stored", exec_operand, 64'hA3A2A1A0);
    rdp(8'hF8, rd); chk("R9 status busy+err", rd, 16'h0005);
    done_pulse();
    wr(1, 8'hFA, 16'h0099, 1);
    rdp(8'hF8, rd); chk("R9 idle write ignored, err sticky", rd, 16'h0004);
    chk("R9 idle write no valid", exec_valid, 0);
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_decode();
    t_zero_byte();
    t_two_byte();
    t_eight_byte();
    t_proto_err();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule